// File: doc/BRIEF.md
# Fully Associative Translation Buffer Manager

This block holds a 64-entry fully associative translation buffer together with the small register file that software uses to maintain it. Each entry pairs a 64-bit tag with a 64-bit translation table entry (TTE). An entry counts as valid when TTE bit 63 is set and as locked when TTE bit 6 is set.

Software reaches the block through a single request port. A request is a read or a write aimed at one of five address spaces. The register space holds the tag-access register, the fault status register and the fault address register. The data-in space writes an entry and lets the block pick the victim. The data-access space reads or writes an entry chosen by address. The tag-read space probes the buffer for a tag. The enable space holds the two translation-enable bits.

Any change of the enable bits invalidates every entry in the same edge, because translations loaded under the old setting must not survive the change. A separate fault-report input lets the translation logic record a fault status and address. Reads return their result one cycle after the request.

Top module: `tlb_assoc_mgr`

## Requirements
- R1: An entry is valid only when its TTE bit 63 is 1. The lock bit (TTE bit 6) has no bearing on validity, so an invalid entry with its lock bit set is still the first choice for replacement.
- R2: A write to the data-in space (req_space = 1) stores the tag-access register (register 6) as the tag and req_wdata as the TTE. It targets the lowest-index entry whose TTE bit 63 is 0.
- R3: When no entry is invalid, a data-in write targets the lowest-index entry whose TTE bit 6 is 0.
- R4: When every entry is both valid and locked, a data-in write changes no entry.
- R5: The data-access space (req_space = 2) selects an entry with req_addr[8:3]. A write stores the tag-access register as the tag and req_wdata as the TTE. A read returns that entry's TTE.
- R6: A tag-read (req_space = 3) returns req_wdata when some valid entry's tag equals req_wdata, and returns zero otherwise. Entries that are invalid never match.
- R7: In the register space (req_space = 0), req_addr[6:3] selects one of 16 registers. Register 0 always reads ID_VALUE (default 64'h0000_0000_0053_0001). Writes to registers 0 and 4 are ignored. Every other register reads back the last value written to it.
- R8: A write to register 3 (fault status) with req_wdata[0] = 1 stores req_wdata. With req_wdata[0] = 0 it clears both register 3 and register 4 (fault address).
- R9: A pulse on flt_valid loads flt_status into register 3 and flt_addr into register 4. If it coincides with a software write to those registers, the fault report wins.
- R10: A write to the enable space (req_space = 4) keeps only req_wdata[1:0], and a read returns them in bits [1:0] with zeros above. When the two bits change, bit 63 of every TTE is cleared at that same edge and flush_pulse is high for the following cycle. Writing the value already held causes no flush.
- R11: A read request sets rd_valid and rd_data one cycle later. rd_valid is low one cycle after any cycle with no read request. A read of the data-in space returns zero.
- R12: After reset all TTEs, tags, registers and enable bits are zero, and rd_valid and flush_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 3 | 0 registers, 1 data-in, 2 data-access, 3 tag-read, 4 enable |
| req_addr | input | 12 | Request address; bits [8:3] entry index, bits [6:3] register index |
| req_wdata | input | 64 | Write data, or the tag to compare for a tag-read |
| flt_valid | input | 1 | Fault report strobe |
| flt_status | input | 64 | Fault status to record |
| flt_addr | input | 64 | Fault address to record |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |
| flush_pulse | output | 1 | One cycle after an enable change that flushed all entries |

## Verification
On every cycle the assertions check the read handshake: the one-cycle latency, the absence of stray rd_valid, zero data from the data-in space, and the fixed value of register 0. They also check that a tag-read only ever answers with the probed value or zero, and that every flush pulse traces back to an enable write. The victim order is another matter. It takes the lowest invalid entry, then the lowest unlocked one, and drops the write when all are full and locked. That order, the clearing of the fault registers, the dropping of writes to read-only registers and the clearing of valid bits by a flush all depend on the contents of earlier entries, so only the bench's directed scenarios show them, by reading entries back through the data-access and tag-read spaces.

// File: rtl/tlb_assoc_mgr.sv
module tlb_assoc_mgr #(
  parameter int          ENTRIES   = 64,
  parameter int          DATA_W    = 64,
  parameter int          ADDR_W    = 12,
  parameter int          VALID_BIT = 63,
  parameter int          LOCK_BIT  = 6,
  parameter int          IDX_LSB   = 3,
  parameter int          REG_COUNT = 16,
  parameter logic [63:0] ID_VALUE  = 64'h0000_0000_0053_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              flt_valid,
  input  logic [DATA_W-1:0] flt_status,
  input  logic [DATA_W-1:0] flt_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              flush_pulse
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int REG_W = $clog2(REG_COUNT);
  localparam logic [2:0] SP_REG = 3'd0;
  localparam logic [2:0] SP_DIN = 3'd1;
  localparam logic [2:0] SP_DAC = 3'd2;
  localparam logic [2:0] SP_TAG = 3'd3;
  localparam logic [2:0] SP_ENA = 3'd4;
  localparam logic [REG_W-1:0] R_ID   = REG_W'(0);
  localparam logic [REG_W-1:0] R_STAT = REG_W'(3);
  localparam logic [REG_W-1:0] R_FADR = REG_W'(4);
  localparam logic [REG_W-1:0] R_TACC = REG_W'(6);

  logic [DATA_W-1:0] tag_q [ENTRIES];
  logic [DATA_W-1:0] tte_q [ENTRIES];
  logic [DATA_W-1:0] reg_q [REG_COUNT];
  logic [1:0]        ena_q;

  logic [IDX_W-1:0] ent_idx;
  logic [REG_W-1:0] reg_idx;
  logic             wr_req, rd_req;
  logic             inv_hit, unl_hit, victim_ok;
  logic [IDX_W-1:0] inv_idx, unl_idx, victim;
  logic [DATA_W-1:0] probe_res, rd_next;
  logic             flush;
  logic             unused_bits;

  assign ent_idx = req_addr[IDX_LSB +: IDX_W];
  assign reg_idx = req_addr[IDX_LSB +: REG_W];
  assign wr_req  = req_valid &  req_write;
  assign rd_req  = req_valid & ~req_write;
  assign flush   = wr_req && (req_space == SP_ENA) && (req_wdata[1:0] != ena_q);
  assign unused_bits = ^{req_addr[IDX_LSB-1:0], req_addr[ADDR_W-1:IDX_LSB+IDX_W]};

  always_comb begin
    inv_hit = 1'b0;
    unl_hit = 1'b0;
    inv_idx = '0;
    unl_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!tte_q[i][VALID_BIT]) begin
        inv_hit = 1'b1;
        inv_idx = IDX_W'(i);
      end
      if (!tte_q[i][LOCK_BIT]) begin
        unl_hit = 1'b1;
        unl_idx = IDX_W'(i);
      end
    end
  end

  assign victim_ok = inv_hit | unl_hit;
  assign victim    = inv_hit ? inv_idx : unl_idx;

  always_comb begin
    probe_res = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (tte_q[i][VALID_BIT] && tag_q[i] == req_wdata)
        probe_res = tag_q[i];
  end

  always_comb begin
    case (req_space)
      SP_REG:  rd_next = (reg_idx == R_ID) ? DATA_W'(ID_VALUE) : reg_q[reg_idx];
      SP_DAC:  rd_next = tte_q[ent_idx];
      SP_TAG:  rd_next = probe_res;
      SP_ENA:  rd_next = {{(DATA_W-2){1'b0}}, ena_q};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end
    end else begin
      if (flush)
        for (int i = 0; i < ENTRIES; i++)
          tte_q[i][VALID_BIT] <= 1'b0;
      if (wr_req && req_space == SP_DIN && victim_ok) begin
        tag_q[victim] <= reg_q[R_TACC];
        tte_q[victim] <= req_wdata;
      end
      if (wr_req && req_space == SP_DAC) begin
        tag_q[ent_idx] <= reg_q[R_TACC];
        tte_q[ent_idx] <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < REG_COUNT; r++)
        reg_q[r] <= '0;
    end else begin
      if (wr_req && req_space == SP_REG) begin
        case (reg_idx)
          R_ID, R_FADR: ;
          R_STAT: begin
            if (req_wdata[0])
              reg_q[R_STAT] <= req_wdata;
            else begin
              reg_q[R_STAT] <= '0;
              reg_q[R_FADR] <= '0;
            end
          end
          default: reg_q[reg_idx] <= req_wdata;
        endcase
      end
      if (flt_valid) begin
        reg_q[R_STAT] <= flt_status;
        reg_q[R_FADR] <= flt_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q       <= 2'b00;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      flush_pulse <= 1'b0;
    end else begin
      if (wr_req && req_space == SP_ENA)
        ena_q <= req_wdata[1:0];
      rd_valid    <= rd_req;
      flush_pulse <= flush;
      if (rd_req)
        rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/tlb_assoc_mgr_chk.sv
module tlb_assoc_mgr_chk #(
  parameter int          DATA_W   = 64,
  parameter int          ADDR_W   = 12,
  parameter int          IDX_LSB  = 3,
  parameter logic [63:0] ID_VALUE = 64'h0000_0000_0053_0001
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [2:0]        req_space,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              flt_valid,
  input logic [DATA_W-1:0] flt_status,
  input logic [DATA_W-1:0] flt_addr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              flush_pulse
);
  logic rd_req;
  logic unused_chk;
  assign rd_req = req_valid && !req_write;
  assign unused_chk = ^{flt_valid, flt_status, flt_addr};

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R11
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid); // R11
  AST_DATA_IN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_space == 3'd1) |=> rd_data == '0); // R11
  AST_ID_REGISTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_space == 3'd0 && req_addr[IDX_LSB +: 4] == 4'd0) |=> rd_data == DATA_W'(ID_VALUE)); // R7
  AST_PROBE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_space == 3'd3) |=> (rd_data == '0 || rd_data == $past(req_wdata))); // R6
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(req_valid && req_write && req_space == 3'd4)); // R10
endmodule

bind tlb_assoc_mgr tlb_assoc_mgr_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .ID_VALUE(ID_VALUE)
) u_chk (.*);

// File: tb/sim_tlb_assoc_mgr.sv
module sim_tlb_assoc_mgr;
  localparam logic [63:0] VLD = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LCK = 64'h0000_0000_0000_0040;
  localparam logic [63:0] IDV = 64'h0000_0000_0053_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_space = '0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        flt_valid = 1'b0;
  logic [63:0] flt_status = '0, flt_addr = '0;
  logic        rd_valid, flush_pulse;
  logic [63:0] rd_data;

  int checks = 0, errors = 0;
  logic flush_seen;
  logic [63:0] got;

  always #10 clk = ~clk;

  tlb_assoc_mgr u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .flt_valid(flt_valid), .flt_status(flt_status), .flt_addr(flt_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .flush_pulse(flush_pulse));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sp, input logic [11:0] a, input logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_space = sp; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    flush_seen = flush_pulse;
  endtask

  task automatic rd(input logic [2:0] sp, input logic [11:0] a, input logic [63:0] d,
                    output logic [63:0] v);
    req_valid = 1'b1; req_write = 1'b0; req_space = sp; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 rd_valid", {63'd0, rd_valid}, 64'd1);
    v = rd_data;
  endtask

  task automatic t_reset;
    check("R12 rd_valid", {63'd0, rd_valid}, 64'd0);
    check("R12 flush_pulse", {63'd0, flush_pulse}, 64'd0);
    rd(3'd2, 12'd0, 64'd0, got);      check("R12 entry0 tte", got, 64'd0);
    rd(3'd2, 12'd63 << 3, 64'd0, got); check("R12 entry63 tte", got, 64'd0);
    rd(3'd0, 12'd6 << 3, 64'd0, got);  check("R12 tag-access", got, 64'd0);
    rd(3'd4, 12'd0, 64'd0, got);       check("R12 enable", got, 64'd0);
    @(negedge clk);
    check("R11 idle rd_valid low", {63'd0, rd_valid}, 64'd0);
  endtask

  task automatic t_regs;
    wr(3'd0, 12'd0, 64'h1234);
    rd(3'd0, 12'd0, 64'd0, got);           check("R7 reg0 id", got, IDV);
    wr(3'd0, 12'd4 << 3, 64'h99);
    rd(3'd0, 12'd4 << 3, 64'd0, got);      check("R7 reg4 write ignored", got, 64'd0);
    wr(3'd0, 12'd9 << 3, 64'hDEAD_BEEF);
    rd(3'd0, (12'd9 << 3) | 12'h080, 64'd0, got); check("R7 reg9 via bits 6:3", got, 64'hDEAD_BEEF);
    rd(3'd1, 12'd0, 64'd0, got);           check("R11 data-in read zero", got, 64'd0);
  endtask

  task automatic t_fault;
    flt_valid = 1'b1; flt_status = 64'h55; flt_addr = 64'h1234;
    @(negedge clk);
    flt_valid = 1'b0;
    rd(3'd0, 12'd3 << 3, 64'd0, got); check("R9 status loaded", got, 64'h55);
    rd(3'd0, 12'd4 << 3, 64'd0, got); check("R9 address loaded", got, 64'h1234);
    wr(3'd0, 12'd3 << 3, 64'h81);
    rd(3'd0, 12'd3 << 3, 64'd0, got); check("R8 status stored", got, 64'h81);
    rd(3'd0, 12'd4 << 3, 64'd0, got); check("R8 address kept", got, 64'h1234);
    wr(3'd0, 12'd3 << 3, 64'h80);
    rd(3'd0, 12'd3 << 3, 64'd0, got); check("R8 status cleared", got, 64'd0);
    rd(3'd0, 12'd4 << 3, 64'd0, got); check("R8 address cleared", got, 64'd0);
  endtask

  task automatic t_replace;
    wr(3'd0, 12'd6 << 3, 64'hA000);
    for (int i = 0; i < 64; i++)
      wr(3'd2, 12'(i) << 3, (i == 5 || i == 9) ? (VLD | 64'(i)) : (VLD | LCK | 64'(i)));
    wr(3'd2, (12'd20 << 3) | 12'd4, LCK | 64'd20);
    wr(3'd2, 12'd40 << 3, 64'd40);
    rd(3'd2, 12'd20 << 3, 64'd0, got); check("R5 index ignores bit 2", got, LCK | 64'd20);
    wr(3'd0, 12'd6 << 3, 64'hB000);
    wr(3'd1, 12'd0, VLD | LCK | 64'h111);
    rd(3'd2, 12'd20 << 3, 64'd0, got); check("R1 R2 invalid locked entry taken", got, VLD | LCK | 64'h111);
    rd(3'd3, 12'd0, 64'hB000, got);    check("R2 tag from tag-access", got, 64'hB000);
    wr(3'd0, 12'd6 << 3, 64'hC000);
    wr(3'd1, 12'd0, VLD | LCK | 64'h222);
    rd(3'd2, 12'd40 << 3, 64'd0, got); check("R2 next invalid entry", got, VLD | LCK | 64'h222);
    wr(3'd1, 12'd0, VLD | LCK | 64'h333);
    rd(3'd2, 12'd5 << 3, 64'd0, got);  check("R3 lowest unlocked", got, VLD | LCK | 64'h333);
    rd(3'd2, 12'd9 << 3, 64'd0, got);  check("R3 higher unlocked untouched", got, VLD | 64'd9);
    wr(3'd1, 12'd0, VLD | LCK | 64'h444);
    rd(3'd2, 12'd9 << 3, 64'd0, got);  check("R3 second unlocked", got, VLD | LCK | 64'h444);
    wr(3'd0, 12'd6 << 3, 64'hD000);
    wr(3'd1, 12'd0, VLD | LCK | 64'h555);
    rd(3'd3, 12'd0, 64'hD000, got);    check("R4 dropped write no tag", got, 64'd0);
    rd(3'd2, 12'd0, 64'd0, got);       check("R4 entry0 intact", got, VLD | LCK);
    rd(3'd2, 12'd63 << 3, 64'd0, got); check("R5 R4 entry63 intact", got, VLD | LCK | 64'd63);
  endtask

  task automatic t_probe;
    rd(3'd3, 12'd0, 64'hC000, got); check("R6 match", got, 64'hC000);
    rd(3'd3, 12'd0, 64'hEEEE, got); check("R6 miss", got, 64'd0);
  endtask

  task automatic t_enable;
    wr(3'd4, 12'd0, 64'hFFF0_0002);
    check("R10 flush pulse", {63'd0, flush_seen}, 64'd1);
    @(negedge clk);
    check("R10 pulse one cycle", {63'd0, flush_pulse}, 64'd0);
    rd(3'd4, 12'd0, 64'd0, got);       check("R10 enable bits kept", got, 64'd2);
    rd(3'd2, 12'd20 << 3, 64'd0, got); check("R10 valid bit cleared", got, LCK | 64'h111);
    rd(3'd3, 12'd0, 64'hB000, got);    check("R6 invalid entry no match", got, 64'd0);
    wr(3'd2, 12'd7 << 3, VLD | 64'd7);
    wr(3'd4, 12'd0, 64'h6);
    check("R10 same value no flush", {63'd0, flush_seen}, 64'd0);
    rd(3'd2, 12'd7 << 3, 64'd0, got);  check("R10 entry kept valid", got, VLD | 64'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_fault;
    t_replace;
    t_probe;
    t_enable;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule